// File: doc/BRIEF.md
# Ganged Call Argument Decoder

This block turns a call operation that occupies one or more neighbouring flow-side instruction slots into a flat, ordered list of argument belt positions. The leading slot (slot 0) is the call slot. It carries the call's administration: how the target is reached, the number of arguments and the number of expected results. Each following slot is a ganged slot. A ganged slot contributes three belt-number fields, and its 32-bit manifest is cut into further belt numbers. The decoder walks this storage in a fixed order. It places the arguments into the list that the callee's new belt will be filled from, and it flags calls that cannot be honoured.

All slots of one call arrive in the same cycle, each with its own valid bit. The decoded result is registered and appears one clock later. The belt length is a parameter (8, 16 or 32), and the belt-number width is log2 of it. With the default belt of 16, a ganged slot holds 11 arguments, so a full 16-argument call fits in one call slot plus two ganged slots.

Top module: `gang_call_decode`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, `out_vld` and `out_err` are 0.
- R2: The outputs reflect the slots presented in the previous cycle. When `slot_vld[0]` was 0, `out_vld` and `out_err` are both 0.
- R3: With `call_via_ptr` = 0 (offset mode), call-slot fields 0, 1 and 2 are arguments 0, 1 and 2, and `out_target` equals the call slot's manifest.
- R4: With `call_via_ptr` = 1 (pointer mode), call-slot field 0 is the function-pointer belt position, given zero-extended on `out_target`. Arguments start at call-slot field 1.
- R5: After the call-slot arguments, ganged slot k (k = 1, 2, ...) gives its fields 0, 1, 2 in turn, then its manifest nibbles of BW bits from the least significant one upward. Slot k is read completely before slot k+1. Argument i sits at `out_args[i*BW +: BW]`.
- R6: On a valid output, `out_argc` and `out_resc` equal the counts given with the call, and every list entry at index `out_argc` or above is zero.
- R7: If the argument count exceeds the belt length, `out_err` is 1 and `out_vld` is 0.
- R8: If a ganged slot is needed for the arguments but its valid bit is 0, `out_err` is 1 and `out_vld` is 0.
- R9: Valid ganged slots beyond those the argument count needs are ignored and do not alter the list.
- R10: `out_vld` and `out_err` are never 1 together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| slot_vld | input | N_SLOTS | Per-slot valid; bit 0 is the call slot |
| slot_fields | input | N_SLOTS*3*BW | Three belt-number fields per slot; slot s field j at `(s*3+j)*BW` |
| slot_manifest | input | N_SLOTS*32 | 32-bit manifest per slot; slot s at `s*32` |
| call_via_ptr | input | 1 | 1: target is a belt position in call-slot field 0; 0: target is the call-slot manifest |
| call_argc | input | BW+1 | Number of arguments |
| call_resc | input | BW+1 | Number of expected results |
| out_vld | output | 1 | Decoded call valid |
| out_err | output | 1 | Call could not be decoded |
| out_via_ptr | output | 1 | Registered target mode |
| out_argc | output | BW+1 | Registered argument count |
| out_resc | output | BW+1 | Registered result count |
| out_target | output | 32 | Offset, or zero-extended pointer belt position |
| out_args | output | BELT_LEN*BW | Ordered argument list, entry i at `i*BW` |

## Verification
The assertions assume that the slot inputs matter only in a cycle where `slot_vld[0]` is high. They also assume the counts fit their BW+1-bit ports and that the inputs hold steady around each sampling edge. The stimulus keeps to these assumptions. It changes inputs only on the falling clock edge, and it sweeps every argument count from 0 to one past the belt length, both target modes, and all eight patterns of slot valid bits. That sweep includes patterns with a missing call slot, with missing ganged slots and with surplus ganged slots.

// File: rtl/gang_call_pkg.sv
package gang_call_pkg;
  // belt-number fields carried by every flow slot
  localparam int FIELDS_PER_SLOT = 3;
  // manifest width of every flow slot
  localparam int MANIFEST_W = 32;
endpackage

// File: rtl/gang_call_pool.sv
// Flattens all slot storage into one ordered pool of belt numbers:
// call-slot fields, then per ganged slot its fields and manifest nibbles.
module gang_call_pool
  import gang_call_pkg::*;
#(
  parameter int BW       = 4,
  parameter int N_SLOTS  = 3,
  parameter int MAN_N    = MANIFEST_W / BW,
  parameter int PER_GANG = FIELDS_PER_SLOT + MAN_N,
  parameter int POOL_N   = FIELDS_PER_SLOT + (N_SLOTS - 1) * PER_GANG
) (
  input  logic [N_SLOTS*FIELDS_PER_SLOT*BW-1:0] slot_fields,
  input  logic [N_SLOTS*MANIFEST_W-1:0]         slot_manifest,
  output logic [POOL_N*BW-1:0]                  pool
);
  genvar j, k, m;
  generate
    for (j = 0; j < FIELDS_PER_SLOT; j++) begin : g_call
      assign pool[j*BW +: BW] = slot_fields[j*BW +: BW];
    end
    for (k = 1; k < N_SLOTS; k++) begin : g_gang
      localparam int BASE = FIELDS_PER_SLOT + (k - 1) * PER_GANG;
      for (j = 0; j < FIELDS_PER_SLOT; j++) begin : g_fld
        assign pool[(BASE + j)*BW +: BW] =
          slot_fields[(k*FIELDS_PER_SLOT + j)*BW +: BW];
      end
      for (m = 0; m < MAN_N; m++) begin : g_man
        assign pool[(BASE + FIELDS_PER_SLOT + m)*BW +: BW] =
          slot_manifest[k*MANIFEST_W + m*BW +: BW];
      end
    end
  endgenerate
endmodule

// File: rtl/gang_call_select.sv
// Picks the argument list out of the pool, skipping the pointer field
// in pointer mode and zeroing entries past the argument count.
module gang_call_select #(
  parameter int BW       = 4,
  parameter int BELT_LEN = 16,
  parameter int POOL_N   = 25,
  parameter int CNT_W    = 5
) (
  input  logic [POOL_N*BW-1:0]   pool,
  input  logic                   via_ptr,
  input  logic [CNT_W-1:0]       argc,
  output logic [BELT_LEN*BW-1:0] args
);
  genvar i;
  generate
    for (i = 0; i < BELT_LEN; i++) begin : g_arg
      logic [BW-1:0] direct, shifted;
      assign direct = pool[i*BW +: BW];
      if (i + 1 < POOL_N) begin : g_sh
        assign shifted = pool[(i+1)*BW +: BW];
      end else begin : g_nosh
        assign shifted = '0;
      end
      assign args[i*BW +: BW] = (int'(argc) > i) ? (via_ptr ? shifted : direct) : '0;
    end
  endgenerate
endmodule

// File: rtl/gang_call_check.sv
// Flags a call whose count exceeds the belt or whose needed ganged
// slots are not all present.
module gang_call_check
  import gang_call_pkg::*;
#(
  parameter int BELT_LEN = 16,
  parameter int N_SLOTS  = 3,
  parameter int PER_GANG = 11,
  parameter int CNT_W    = 5
) (
  input  logic [N_SLOTS-1:0] slot_vld,
  input  logic               via_ptr,
  input  logic [CNT_W-1:0]   argc,
  output logic               bad
);
  int  in_call;
  logic short_slot, too_many;
  always_comb begin
    in_call    = via_ptr ? FIELDS_PER_SLOT - 1 : FIELDS_PER_SLOT;
    short_slot = 1'b0;
    for (int k = 1; k < N_SLOTS; k++) begin
      if (int'(argc) > in_call + (k - 1) * PER_GANG && !slot_vld[k])
        short_slot = 1'b1;
    end
    too_many = (int'(argc) > BELT_LEN) ||
               (int'(argc) > in_call + (N_SLOTS - 1) * PER_GANG);
    bad = short_slot | too_many;
  end
endmodule

// File: rtl/gang_call_decode.sv
module gang_call_decode
  import gang_call_pkg::*;
#(
  parameter int BELT_LEN = 16,
  parameter int N_SLOTS  = 3,
  localparam int BW       = $clog2(BELT_LEN),
  localparam int CNT_W    = BW + 1,
  localparam int MAN_N    = MANIFEST_W / BW,
  localparam int PER_GANG = FIELDS_PER_SLOT + MAN_N,
  localparam int POOL_N   = FIELDS_PER_SLOT + (N_SLOTS - 1) * PER_GANG
) (
  input  logic                                clk,
  input  logic                                rst,
  input  logic [N_SLOTS-1:0]                  slot_vld,
  input  logic [N_SLOTS*FIELDS_PER_SLOT*BW-1:0] slot_fields,
  input  logic [N_SLOTS*MANIFEST_W-1:0]       slot_manifest,
  input  logic                                call_via_ptr,
  input  logic [CNT_W-1:0]                    call_argc,
  input  logic [CNT_W-1:0]                    call_resc,
  output logic                                out_vld,
  output logic                                out_err,
  output logic                                out_via_ptr,
  output logic [CNT_W-1:0]                    out_argc,
  output logic [CNT_W-1:0]                    out_resc,
  output logic [MANIFEST_W-1:0]               out_target,
  output logic [BELT_LEN*BW-1:0]              out_args
);
  logic [POOL_N*BW-1:0]   pool;
  logic [BELT_LEN*BW-1:0] args_c;
  logic                   bad_c;
  logic [MANIFEST_W-1:0]  target_c;

  gang_call_pool #(.BW(BW), .N_SLOTS(N_SLOTS), .MAN_N(MAN_N),
                   .PER_GANG(PER_GANG), .POOL_N(POOL_N)) pool_i (
    .slot_fields   (slot_fields),
    .slot_manifest (slot_manifest),
    .pool          (pool)
  );

  gang_call_select #(.BW(BW), .BELT_LEN(BELT_LEN), .POOL_N(POOL_N),
                     .CNT_W(CNT_W)) sel_i (
    .pool    (pool),
    .via_ptr (call_via_ptr),
    .argc    (call_argc),
    .args    (args_c)
  );

  gang_call_check #(.BELT_LEN(BELT_LEN), .N_SLOTS(N_SLOTS),
                    .PER_GANG(PER_GANG), .CNT_W(CNT_W)) chk_i (
    .slot_vld (slot_vld),
    .via_ptr  (call_via_ptr),
    .argc     (call_argc),
    .bad      (bad_c)
  );

  assign target_c = call_via_ptr ? MANIFEST_W'(slot_fields[BW-1:0])
                                 : slot_manifest[MANIFEST_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      out_vld     <= 1'b0;
      out_err     <= 1'b0;
      out_via_ptr <= 1'b0;
      out_argc    <= '0;
      out_resc    <= '0;
      out_target  <= '0;
      out_args    <= '0;
    end else begin
      out_vld <= slot_vld[0] & ~bad_c;
      out_err <= slot_vld[0] & bad_c;
      if (slot_vld[0]) begin
        out_via_ptr <= call_via_ptr;
        out_argc    <= call_argc;
        out_resc    <= call_resc;
        out_target  <= target_c;
        out_args    <= args_c;
      end
    end
  end
endmodule

// File: rtl/gang_call_decode_chk.sv
module gang_call_decode_chk #(
  parameter int BELT_LEN = 16,
  parameter int N_SLOTS  = 3,
  parameter int BW       = 4,
  parameter int CNT_W    = 5
) (
  input logic               clk,
  input logic               rst,
  input logic [N_SLOTS-1:0] slot_vld,
  input logic [CNT_W-1:0]   call_argc,
  input logic [CNT_W-1:0]   call_resc,
  input logic               out_vld,
  input logic               out_err,
  input logic [CNT_W-1:0]   out_argc,
  input logic [CNT_W-1:0]   out_resc
);
  p_excl_r10: assert property (@(posedge clk) disable iff (rst)
    !(out_vld && out_err));

  p_idle_r2: assert property (@(posedge clk) disable iff (rst)
    !slot_vld[0] |=> (!out_vld && !out_err));

  p_over_r7: assert property (@(posedge clk) disable iff (rst)
    (slot_vld[0] && int'(call_argc) > BELT_LEN) |=> (out_err && !out_vld));

  p_cap_r7: assert property (@(posedge clk) disable iff (rst)
    out_vld |-> int'(out_argc) <= BELT_LEN);

  p_echo_r6: assert property (@(posedge clk) disable iff (rst)
    slot_vld[0] |=> (out_argc == $past(call_argc) && out_resc == $past(call_resc)));
endmodule

bind gang_call_decode gang_call_decode_chk #(
  .BELT_LEN(BELT_LEN), .N_SLOTS(N_SLOTS), .BW(BW), .CNT_W(CNT_W)
) sva_i (
  .clk(clk), .rst(rst), .slot_vld(slot_vld), .call_argc(call_argc),
  .call_resc(call_resc), .out_vld(out_vld), .out_err(out_err),
  .out_argc(out_argc), .out_resc(out_resc)
);

// File: tb/gang_call_decode_tb_top.sv
`timescale 1ns/1ps
module gang_call_decode_tb_top;
  localparam int BELT = 16;
  localparam int NS   = 3;
  localparam int BW   = 4;
  localparam int CW   = 5;
  localparam int PER  = 11;

  logic              clk = 1'b0;
  logic              rst;
  logic [NS-1:0]     slot_vld;
  logic [NS*3*BW-1:0] slot_fields;
  logic [NS*32-1:0]  slot_manifest;
  logic              call_via_ptr;
  logic [CW-1:0]     call_argc, call_resc;
  logic              out_vld, out_err, out_via_ptr;
  logic [CW-1:0]     out_argc, out_resc;
  logic [31:0]       out_target;
  logic [BELT*BW-1:0] out_args;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  always #2 clk = ~clk;

  gang_call_decode #(.BELT_LEN(BELT), .N_SLOTS(NS)) dut_i (
    .clk(clk), .rst(rst), .slot_vld(slot_vld), .slot_fields(slot_fields),
    .slot_manifest(slot_manifest), .call_via_ptr(call_via_ptr),
    .call_argc(call_argc), .call_resc(call_resc), .out_vld(out_vld),
    .out_err(out_err), .out_via_ptr(out_via_ptr), .out_argc(out_argc),
    .out_resc(out_resc), .out_target(out_target), .out_args(out_args)
  );

  function automatic logic [BW-1:0] val(int p, int s);
    return BW'(p * 5 + s * 3 + 1);
  endfunction

  task automatic check(string tag, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic drive(int s, int argc, bit ptr, logic [NS-1:0] v);
    slot_vld     = v;
    call_via_ptr = ptr;
    call_argc    = CW'(argc);
    call_resc    = CW'(s % 7);
    for (int j = 0; j < 3; j++) slot_fields[j*BW +: BW] = val(j, s);
    slot_manifest[31:0] = 32'hC0DE0000 ^ 32'(s * 977);
    for (int k = 1; k < NS; k++) begin
      int base = 3 + (k - 1) * PER;
      for (int j = 0; j < 3; j++) slot_fields[(k*3+j)*BW +: BW] = val(base + j, s);
      for (int m = 0; m < 8; m++) slot_manifest[k*32 + m*BW +: BW] = val(base + 3 + m, s);
    end
  endtask

  initial begin
    #800000;
    n_bad++;
    $display("FAIL R2 watchdog act=hung exp=done");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    int s = 0;
    rst = 1'b1;
    drive(0, 0, 1'b0, '0);
    repeat (3) @(negedge clk);
    check("R1 reset vld", out_vld, 0);
    check("R1 reset err", out_err, 0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 post-reset vld", out_vld, 0);
    check("R1 post-reset err", out_err, 0);

    for (int argc = 0; argc <= BELT + 1; argc++) begin
      for (int ptr = 0; ptr < 2; ptr++) begin
        for (int v = 0; v < 8; v++) begin
          int cs, need, off;
          bit err, vld, extra;
          s++;
          drive(s, argc, ptr[0], NS'(v));
          cs    = ptr ? 2 : 3;
          off   = ptr;
          need  = (argc <= cs) ? 0 : (argc - cs + PER - 1) / PER;
          err   = (argc > BELT) || (need > NS - 1);
          for (int k = 1; k <= need && k < NS; k++) if (!v[k]) err = 1;
          err   = err && v[0];
          vld   = v[0] && !err;
          extra = vld && (need < NS - 1) && (v[NS-1] != 0);
          @(negedge clk);
          if (!v[0]) begin
            check("R2 idle vld", out_vld, 0);
            check("R2 idle err", out_err, 0);
          end else if (argc > BELT) begin
            check("R7 over err", out_err, 1);
            check("R7 over vld", out_vld, 0);
          end else if (err) begin
            check("R8 short err", out_err, 1);
            check("R8 short vld", out_vld, 0);
          end else begin
            check("R10 vld", out_vld, 1);
            check("R10 err", out_err, 0);
            check("R6 argc", out_argc, argc);
            check("R6 resc", out_resc, s % 7);
            if (ptr) check("R4 target", out_target, val(0, s));
            else     check("R3 target", out_target, 32'hC0DE0000 ^ 32'(s * 977));
            for (int i = 0; i < BELT; i++) begin
              string tag;
              longint exp;
              exp = (i < argc) ? val(i + off, s) : 0;
              if (i >= argc)   tag = "R6 zero tail";
              else if (extra)  tag = "R9 extra slot arg";
              else if (i < cs) tag = ptr ? "R4 arg" : "R3 arg";
              else             tag = "R5 gang arg";
              check(tag, out_args[i*BW +: BW], exp);
            end
          end
        end
      end
    end
    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule